// File: doc/BRIEF.md
# Masked BSSID Receive Filter

This block decides, frame by frame, whether a received 48-bit BSSID should be treated as addressed to the local device. The device may host several virtual networks behind one station address. Software loads two 48-bit values: the station address and a match mask. A frame is accepted when its BSSID agrees with the station address in every bit position the mask selects. Bits where the mask is zero are ignored.

Software derives the mask. It ANDs together `~(station ^ bssid)` over every hosted BSSID, so that the mask keeps only the positions where all of them agree with the station address. Some frames that belong to none of the hosted networks can still pass, and this is expected. An all-ones mask gives exact matching for a single network. An all-zero mask accepts everything.

Each 48-bit register is written as two words, and the new value becomes active only once both words have been written. The frame side takes a BSSID with a valid strobe. One clock later it returns a result valid together with an accept flag.

Top module: `bssid_rx_filter`

## Requirements
- R1: With `res_valid` high, `res_accept` is 1 exactly when `(bssid & mask) == (mask & station)` for the frame presented one clock earlier, and 0 otherwise.
- R2: `res_valid` is high in the cycle after a cycle with `frm_valid` high, and low in the cycle after a cycle with `frm_valid` low.
- R3: `res_accept` is 0 whenever `res_valid` is 0.
- R4: After reset the mask is all ones and the station address is zero, so only BSSID 0 is accepted.
- R5: Write select codes are 0 = station low word, 1 = station high word, 2 = mask low word, 3 = mask high word. Values are packed little-endian: byte 0 sits in bits [7:0] of the low word, and bytes 4 and 5 sit in bits [15:0] of the high word. Bits [31:16] of a high-word write are ignored.
- R6: A write to one half of a register has no effect on filtering until the other half of the same register has also been written. The two halves may be written in either order. The new value is active from the cycle after the completing write.
- R7: An all-ones mask accepts only a BSSID equal to the station address, and rejects a difference in any single bit, including bit 0 and bit 47.
- R8: An all-zero mask accepts every frame.
- R9: Take station 0x1 and mask 0x2, with all other bits zero. Under these settings BSSIDs 0x4, 0x9 and 0x1 are accepted and 0x6 is rejected. BSSID 0xD is also accepted, which is a false accept.
- R10: If the same half is written twice before its partner, the later value is the one committed.
- R11: A frame presented in the same cycle as a completing register write is judged against the previous register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register half select (R5 codes) |
| cfg_wdata | input | 32 | Write data word |
| frm_valid | input | 1 | Frame BSSID valid strobe |
| frm_bssid | input | 48 | Received BSSID, byte 0 in bits [7:0] |
| res_valid | output | 1 | Result valid, one clock after `frm_valid` |
| res_accept | output | 1 | Frame accepted |

## Verification
The bench builds the block with its default widths: a 48-bit address and a 32-bit write word, which leaves a 16-bit high half. With these widths, the unused upper bits of a high-word write can be driven with junk to show they have no effect. Bit 47 sits in the high half while bit 0 sits in the low half, so single-bit misses are checked on both sides of the split. The small worked example is placed in the low nibble, with every other mask bit cleared. This makes the example's false accept appear in a full-width frame.

// File: rtl/bssid_filt_pkg.sv
// Package: bssid_filt_pkg
// Shared encodings for the masked BSSID receive filter.
// Assumes the write word holds the low part of a register and the high
// word holds the remainder, both little-endian.
package bssid_filt_pkg;

    // Register half selected by a configuration write.
    typedef enum logic [1:0] {
        SEL_STA_LO  = 2'd0,
        SEL_STA_HI  = 2'd1,
        SEL_MASK_LO = 2'd2,
        SEL_MASK_HI = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/bssid_split_reg.sv
// Module: bssid_split_reg
// Holds one active ADDR_W-bit value that is loaded through two word writes.
// The low half is WORD_W bits and the high half is ADDR_W-WORD_W bits.
// A half is staged until its partner half arrives. The write that
// completes the pair commits both halves together, in either order.
// Assumes ADDR_W > WORD_W and ADDR_W - WORD_W <= WORD_W.
module bssid_split_reg #(
    parameter int          ADDR_W  = 48,
    parameter int          WORD_W  = 32,
    parameter logic [ADDR_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [ADDR_W-1:0] value
);
    localparam int HI_W = ADDR_W - WORD_W;

    logic [WORD_W-1:0] lo_stage;
    logic [WORD_W-1:0] hi_stage;
    logic              lo_held;
    logic              hi_held;
    logic              commit;
    logic [ADDR_W-1:0] next_val;

    // Decide whether this write completes a pair and what value it commits.
    always_comb begin
        commit   = (wr_lo && hi_held) || (wr_hi && lo_held);
        next_val = value;
        if (wr_lo && hi_held)
            next_val = {hi_stage[HI_W-1:0], wdata};
        else if (wr_hi && lo_held)
            next_val = ADDR_W'({wdata, lo_stage});
    end

    // Stage lone halves and clear the staging flags on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_stage <= '0;
            hi_stage <= '0;
            lo_held  <= 1'b0;
            hi_held  <= 1'b0;
        end else if (commit) begin
            lo_held  <= 1'b0;
            hi_held  <= 1'b0;
        end else begin
            if (wr_lo) begin
                lo_stage <= wdata;
                lo_held  <= 1'b1;
            end
            if (wr_hi) begin
                hi_stage <= wdata;
                hi_held  <= 1'b1;
            end
        end
    end

    // Active value: the reset constant, then each committed pair.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= RST_VAL;
        else if (commit)
            value <= next_val;
    end

    // R6: the active value moves only on a completing write.
    assert_hold_until_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(value));

    // R6: both halves are never staged at once, because the second one commits.
    assert_single_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_held && hi_held));

endmodule

// File: rtl/bssid_match_core.sv
// Module: bssid_match_core
// Compares a frame BSSID with the station address at the positions that
// the mask selects. Each byte lane is compared separately and the lane
// results are reduced. The verdict is registered once, qualified by a valid.
// Assumes ADDR_W is a multiple of 8.
module bssid_match_core #(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] bssid,
    input  logic [ADDR_W-1:0] station,
    input  logic [ADDR_W-1:0] mask,
    output logic              out_valid,
    output logic              out_accept
);
    localparam int LANES = ADDR_W / 8;

    logic [LANES-1:0] lane_ok;
    logic             hit;

    // One comparator per byte lane: no selected bit may differ.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] diff;
        assign diff       = (bssid[g*8 +: 8] & mask[g*8 +: 8]) ^
                            (station[g*8 +: 8] & mask[g*8 +: 8]);
        assign lane_ok[g] = (diff == 8'h00);
    end

    assign hit = &lane_ok;

    // Register the verdict; accept stays low without a valid frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_accept <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            out_accept <= in_valid && hit;
        end
    end

    // R2: the result follows the strobe by exactly one clock.
    assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3: accept is qualified by valid.
    assert_accept_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_accept);

    // R7: an all-ones mask is exact equality.
    assert_exact_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&mask)) |=> (out_accept == ($past(bssid) == $past(station))));

    // R8: an all-zero mask accepts any frame.
    assert_open_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mask == '0)) |=> out_accept);

endmodule

// File: rtl/bssid_rx_filter.sv
// Module: bssid_rx_filter
// Top of the masked BSSID receive filter. It decodes configuration writes
// into the station-address and mask register halves, holds both registers,
// and judges each frame BSSID against them.
// Assumes at most one configuration write per cycle.
module bssid_rx_filter #(
    parameter int ADDR_W = 48,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              frm_valid,
    input  logic [ADDR_W-1:0] frm_bssid,
    output logic              res_valid,
    output logic              res_accept
);
    import bssid_filt_pkg::*;

    localparam logic [ADDR_W-1:0] MASK_RST = '1;
    localparam logic [ADDR_W-1:0] STA_RST  = '0;

    cfg_sel_e          sel;
    logic              sta_wr_lo, sta_wr_hi, mask_wr_lo, mask_wr_hi;
    logic [ADDR_W-1:0] sta_q;
    logic [ADDR_W-1:0] mask_q;

    // Decode the write select into one strobe per register half.
    always_comb begin
        sel        = cfg_sel_e'(cfg_sel);
        sta_wr_lo  = cfg_wr && (sel == SEL_STA_LO);
        sta_wr_hi  = cfg_wr && (sel == SEL_STA_HI);
        mask_wr_lo = cfg_wr && (sel == SEL_MASK_LO);
        mask_wr_hi = cfg_wr && (sel == SEL_MASK_HI);
    end

    // Station address register, zero after reset.
    bssid_split_reg #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .RST_VAL(STA_RST)) u_sta (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (sta_wr_lo),
        .wr_hi (sta_wr_hi),
        .wdata (cfg_wdata),
        .value (sta_q)
    );

    // Mask register, all ones after reset for exact matching.
    bssid_split_reg #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .RST_VAL(MASK_RST)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (mask_wr_lo),
        .wr_hi (mask_wr_hi),
        .wdata (cfg_wdata),
        .value (mask_q)
    );

    // Frame comparator and result register.
    bssid_match_core #(.ADDR_W(ADDR_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (frm_valid),
        .bssid      (frm_bssid),
        .station    (sta_q),
        .mask       (mask_q),
        .out_valid  (res_valid),
        .out_accept (res_accept)
    );

    // R5: the four write strobes are mutually exclusive.
    assert_one_half_per_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sta_wr_lo, sta_wr_hi, mask_wr_lo, mask_wr_hi}));

    // R1: a result always follows a frame, and an accept needs a valid.
    assert_accept_needs_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_accept |-> $past(frm_valid));

endmodule

// File: tb/tb_bssid_rx_filter.sv
module tb_bssid_rx_filter;
    localparam int AW = 48;
    localparam int WW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [WW-1:0] cfg_wdata = '0;
    logic          frm_valid = 1'b0;
    logic [AW-1:0] frm_bssid = '0;
    logic          res_valid;
    logic          res_accept;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    bssid_rx_filter #(.ADDR_W(AW), .WORD_W(WW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_bssid(frm_bssid),
        .res_valid(res_valid), .res_accept(res_accept)
    );

    typedef struct packed {
        logic [AW-1:0] mask;
        logic [AW-1:0] sta;
        logic [AW-1:0] frame;
        logic          acc;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{48'h2, 48'h1, 48'h4, 1'b1},                                // R9
        '{48'h2, 48'h1, 48'h9, 1'b1},                                // R9
        '{48'h2, 48'h1, 48'h1, 1'b1},                                // R9
        '{48'h2, 48'h1, 48'h6, 1'b0},                                // R9
        '{48'h2, 48'h1, 48'hD, 1'b1},                                // R9 false accept
        '{48'hFFFF_FFFF_FFFF, 48'h0A0B_0C0D_0E0F, 48'h0A0B_0C0D_0E0F, 1'b1}, // R7
        '{48'hFFFF_FFFF_FFFF, 48'h0A0B_0C0D_0E0F, 48'h8A0B_0C0D_0E0F, 1'b0}, // R7 bit 47
        '{48'hFFFF_FFFF_FFFF, 48'h0A0B_0C0D_0E0F, 48'h0A0B_0C0D_0E0E, 1'b0}, // R7 bit 0
        '{48'h0, 48'h0A0B_0C0D_0E0F, 48'h5A5A_1234_9876, 1'b1},      // R8
        '{48'hFF00_0000_00FF, 48'h1200_0000_0034, 48'h12AB_CDEF_0134, 1'b1}, // R1
        '{48'hFF00_0000_00FF, 48'h1200_0000_0034, 48'h13AB_CDEF_0134, 1'b0}  // R1
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [WW-1:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic program_all(input logic [AW-1:0] sta, input logic [AW-1:0] mask);
        wr(2'd0, sta[31:0]);
        wr(2'd1, {16'h0, sta[47:32]});
        wr(2'd2, mask[31:0]);
        wr(2'd3, {16'h0, mask[47:32]});
    endtask

    // Present one frame, then sample the result one clock later.
    task automatic frame(input string req, input logic [AW-1:0] b, input logic exp);
        @(negedge clk);
        frm_valid = 1'b1; frm_bssid = b;
        @(negedge clk);
        frm_valid = 1'b0;
        check({req, " valid"}, res_valid, 1'b1);
        check(req, res_accept, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2/R3: idle after reset
        check("R2 idle valid", res_valid, 1'b0);
        check("R3 idle accept", res_accept, 1'b0);
        // R4: reset state
        frame("R4 zero bssid", 48'h0, 1'b1);
        frame("R4 nonzero bssid", 48'h1, 1'b0);
        frame("R4 high bit", 48'h8000_0000_0000, 1'b0);
        @(negedge clk);
        check("R2 no frame valid", res_valid, 1'b0);
        check("R3 no frame accept", res_accept, 1'b0);

        // Vector table (R1, R7, R8, R9)
        for (int i = 0; i < NV; i++) begin
            program_all(VECS[i].sta, VECS[i].mask);
            frame($sformatf("R1 vector %0d", i), VECS[i].frame, VECS[i].acc);
        end

        // R5: junk in upper bits of high write ignored; byte order
        program_all(48'h0, 48'hFFFF_FFFF_FFFF);
        wr(2'd0, 32'h4433_2211);
        wr(2'd1, 32'hDEAD_6655);
        frame("R5 packing", 48'h6655_4433_2211, 1'b1);
        frame("R5 byte swap", 48'h1122_3344_5566, 1'b0);

        // R6: lone low half has no effect, pair commits
        wr(2'd2, 32'h0);
        frame("R6 lone mask low", 48'h6655_0000_0000, 1'b0);
        wr(2'd3, 32'h0);
        frame("R6 mask pair", 48'h1234_5678_9ABC, 1'b1);
        // R6: high-first order
        program_all(48'h0000_0000_00A1, 48'hFFFF_FFFF_FFFF);
        wr(2'd1, 32'h0000_BEEF);
        frame("R6 lone sta high old", 48'h0000_0000_00A1, 1'b1);
        frame("R6 lone sta high new", 48'hBEEF_0000_00A1, 1'b0);
        wr(2'd0, 32'h0000_00A1);
        frame("R6 hi-lo pair", 48'hBEEF_0000_00A1, 1'b1);

        // R10: later write of the same half wins
        wr(2'd0, 32'h1111_1111);
        wr(2'd0, 32'h2222_2222);
        wr(2'd1, 32'h0000_3333);
        frame("R10 last value", 48'h3333_2222_2222, 1'b1);
        frame("R10 first value", 48'h3333_1111_1111, 1'b0);

        // R11: frame in the same cycle as the completing write
        wr(2'd0, 32'h0000_0077);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 2'd1; cfg_wdata = 32'h0000_0066;
        frm_valid = 1'b1; frm_bssid = 48'h3333_2222_2222;
        @(negedge clk);
        cfg_wr = 1'b0; frm_valid = 1'b0;
        check("R11 old value judged", res_accept, 1'b1);
        frame("R11 new value active", 48'h0066_0000_0077, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule